// File: doc/BRIEF.md
# Six-Channel Register File with Width-Checked Access

This block is the register file behind the bus slave port of a six-channel acquisition card. It turns a byte address into one global control word or into one of the 16-bit words of a channel bank. The six banks are identical and sit back to back, 0x28 bytes apart, starting at byte 0x08. An access carries a width select, so it moves either one 16-bit word or two adjacent words as one 32-bit item.

A 32-bit access is taken only at the base of a word pair that the channel layout marks as wide-capable. Any other wide access is refused with a bus-error pulse, and no word changes. The block never splits such an access into two halves. The global word at byte 0x00 holds a single mask bit, which gates the card's internal fault request onto the sysfail output.

Every request receives exactly one response one clock later: either an acknowledge, with read data where it applies, or a bus error.

Top module: `mc_regfile`

## Requirements
- R1: After reset every channel word and the global word read as 0x0000, `ack_o` and `berr_o` are low, and the sysfail mask is clear.
- R2: A 16-bit access at any even address from 0x08 to 0xF7 writes or reads one word. Read data is placed in bits 15:0, and bits 31:16 read as zero.
- R3: A 32-bit access at a wide-capable pair base moves the word at the lower address on bits 31:16 and the next word on bits 15:0. The pair bases lie at channel-relative byte offsets 0x04, 0x08, 0x0C, 0x10, 0x1C, 0x20 and 0x24, where the channel base is 0x08 + 0x28 × channel.
- R4: A 32-bit access at any other channel word gives a bus error. A refused write leaves both the addressed word and the word after it unchanged.
- R5: An odd address, an address from 0x02 to 0x07, or an address of 0xF8 and above gives a bus error at either width and changes no state.
- R6: Each request cycle is answered in the next cycle by exactly one of `ack_o` and `berr_o`. Neither output is raised in a cycle that follows a cycle with no request.
- R7: The global word at 0x00 accepts only 16-bit access. Bit 14 is the sysfail mask, and all other bits read 0 and ignore writes. A 32-bit access to 0x00 gives a bus error.
- R8: `sysfail_o` follows `fault_i` while the mask bit is 0 and is held low while the mask bit is 1.
- R9: Channel banks are independent. A write to one channel's word leaves the same word of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data (bits 15:0 for a 16-bit access) |
| ack_o | output | 1 | Access completed, one cycle after request |
| berr_o | output | 1 | Access refused, one cycle after request |
| rdata_o | output | 32 | Read data, valid with `ack_o` |
| fault_i | input | 1 | Internal fault request |
| sysfail_o | output | 1 | Masked fault output |

## Verification
A wrong decode shows up as a bus error or an acknowledge of the wrong kind, one cycle after the offending request. A wrong pair table or a wrong channel stride instead corrupts a word in some other place. That corruption stays hidden until the word is read back, so every refused or cross-channel write is followed at once by reads of the addressed word, the word after it and the same word in another channel. A stale mask bit appears on `sysfail_o` in the cycle right after the write to the global word.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_GLOBAL, TGT_CHAN} tgt_e;

  localparam int unsigned MASK_BIT = 14;

  // channel-relative byte offsets where a 32-bit pair may start
  function automatic logic pair_base(input int unsigned off);
    case (off)
      4, 8, 12, 16, 28, 32, 36: return 1'b1;
      default:                  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mcr_decode.sv
module mcr_decode
  import mcr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned N_CH      = 6,
  parameter int unsigned CH_BASE   = 8,
  parameter int unsigned CH_STRIDE = 40,
  localparam int unsigned WORDS    = CH_STRIDE / 2,
  localparam int unsigned IDX_W    = $clog2(WORDS),
  localparam int unsigned CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output tgt_e              tgt_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              legal_o
);
  localparam int unsigned EW = ADDR_W + 1;

  logic [EW-1:0]   a_ext;
  logic [N_CH-1:0] in_rng;
  logic [EW-1:0]   off_c [N_CH];
  logic [EW-1:0]   off_sel;

  assign a_ext = {1'b0, addr_i};

  for (genvar c = 0; c < N_CH; c++) begin : g_rng
    localparam int unsigned LO = CH_BASE + c * CH_STRIDE;
    localparam int unsigned HI = LO + CH_STRIDE;
    assign in_rng[c] = (a_ext >= EW'(LO)) && (a_ext < EW'(HI));
    assign off_c[c]  = a_ext - EW'(LO);
  end

  always_comb begin
    tgt_o   = TGT_NONE;
    ch_o    = '0;
    off_sel = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (in_rng[c]) begin
        tgt_o   = TGT_CHAN;
        ch_o    = CH_W'(c);
        off_sel = off_c[c];
      end
    end
    if (a_ext == '0) tgt_o = TGT_GLOBAL;
  end

  assign idx_o = IDX_W'(off_sel >> 1);

  always_comb begin
    legal_o = 1'b0;
    if (!addr_i[0]) begin
      unique case (tgt_o)
        TGT_GLOBAL: legal_o = !wide_i;
        TGT_CHAN:   legal_o = !wide_i || pair_base(int'(off_sel));
        default:    legal_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mcr_chan.sv
module mcr_chan #(
  parameter int unsigned WORDS = 20,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wide_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [15:0]      regs_q [WORDS];
  logic [IDX_W-1:0] idx_nxt;

  assign idx_nxt = idx_i + IDX_W'(1);

  function automatic logic [15:0] rd_word(input logic [IDX_W-1:0] i);
    logic [15:0] v;
    v = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (i == IDX_W'(w)) v = regs_q[w];
    end
    return v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) regs_q[w] <= '0;
    end else if (wr_en_i) begin
      for (int w = 0; w < WORDS; w++) begin
        if (wide_i) begin
          if (idx_i == IDX_W'(w))   regs_q[w] <= wdata_i[31:16];
          if (idx_nxt == IDX_W'(w)) regs_q[w] <= wdata_i[15:0];
        end else if (idx_i == IDX_W'(w)) begin
          regs_q[w] <= wdata_i[15:0];
        end
      end
    end
  end

  assign rdata_o = wide_i ? {rd_word(idx_i), rd_word(idx_nxt)}
                          : {16'h0000, rd_word(idx_i)};
endmodule

// File: rtl/mcr_global.sv
module mcr_global
  import mcr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        mask_d_i,
  input  logic        fault_i,
  output logic [15:0] rdata_o,
  output logic        sysfail_o
);
  logic mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= 1'b0;
    else if (wr_en_i) mask_q <= mask_d_i;
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[MASK_BIT] = mask_q;
  end

  assign sysfail_o = fault_i && !mask_q;
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mcr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned N_CH      = 6,
  parameter int unsigned CH_BASE   = 8,
  parameter int unsigned CH_STRIDE = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              ack_o,
  output logic              berr_o,
  output logic [31:0]       rdata_o,
  input  logic              fault_i,
  output logic              sysfail_o
);
  localparam int unsigned WORDS = CH_STRIDE / 2;
  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1;

  tgt_e             tgt;
  logic [CH_W-1:0]  ch_sel;
  logic [IDX_W-1:0] idx;
  logic             legal;
  logic             wr_ok;
  logic [15:0]      gbl_rd;
  logic [31:0]      ch_rd [N_CH];
  logic [31:0]      rd_mux;
  logic             ack_q, berr_q;
  logic [31:0]      rdata_q;

  mcr_decode #(
    .ADDR_W(ADDR_W), .N_CH(N_CH), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
  ) i_decode (
    .addr_i (addr_i),
    .wide_i (wide_i),
    .tgt_o  (tgt),
    .ch_o   (ch_sel),
    .idx_o  (idx),
    .legal_o(legal)
  );

  assign wr_ok = req_i && we_i && legal;

  mcr_global i_global (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_ok && (tgt == TGT_GLOBAL)),
    .mask_d_i (wdata_i[MASK_BIT]),
    .fault_i  (fault_i),
    .rdata_o  (gbl_rd),
    .sysfail_o(sysfail_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    mcr_chan #(.WORDS(WORDS)) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(wr_ok && (tgt == TGT_CHAN) && (ch_sel == CH_W'(c))),
      .wide_i (wide_i),
      .idx_i  (idx),
      .wdata_i(wdata_i),
      .rdata_o(ch_rd[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (tgt == TGT_GLOBAL) rd_mux = {16'h0000, gbl_rd};
    else if (tgt == TGT_CHAN) begin
      for (int c = 0; c < N_CH; c++) begin
        if (ch_sel == CH_W'(c)) rd_mux = ch_rd[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      berr_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q  <= req_i && legal;
      berr_q <= req_i && !legal;
      if (req_i) rdata_q <= (legal && !we_i) ? rd_mux : '0;
    end
  end

  assign ack_o   = ack_q;
  assign berr_o  = berr_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mc_regfile_chk.sv
module mc_regfile_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              wide_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              ack_o,
  input logic              berr_o,
  input logic [31:0]       rdata_o,
  input logic              fault_i,
  input logic              sysfail_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(248);

  assert_one_resp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (ack_o ^ berr_o));

  assert_no_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!ack_o && !berr_o));

  assert_odd_addr_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[0]) |=> berr_o);

  assert_high_addr_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (addr_i >= TOP_ADDR)) |=> berr_o);

  assert_gbl_wide_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wide_i && (addr_i == '0)) |=> berr_o);

  assert_gbl_reserved_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !wide_i && (addr_i == '0)) |=>
      (rdata_o[31:15] == '0 && rdata_o[13:0] == '0));

  assert_narrow_hi_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wide_i) |=> (rdata_o[31:16] == '0));

  assert_mask_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !wide_i && (addr_i == '0) && wdata_i[14]) |=> !sysfail_o);

  assert_sysfail_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysfail_o |-> fault_i);
endmodule

bind mc_regfile mc_regfile_chk #(.ADDR_W(ADDR_W)) i_mc_regfile_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .wide_i   (wide_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .ack_o    (ack_o),
  .berr_o   (berr_o),
  .rdata_o  (rdata_o),
  .fault_i  (fault_i),
  .sysfail_o(sysfail_o)
);

// File: tb/test_mc_regfile.sv
module test_mc_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, wide_i = 1'b0, fault_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ack_o, berr_o, sysfail_o;
  logic [31:0] rdata_o;

  int n_chk = 0, n_fail = 0, n_req = 0, n_resp = 0;
  bit done = 1'b0;

  typedef struct {bit err; bit chk; logic [31:0] data; string tag;} exp_t;
  exp_t sb[$];
  logic [15:0] mdl [128];

  always #5 clk_i = ~clk_i;

  mc_regfile i_mc_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .wide_i(wide_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ack_o(ack_o), .berr_o(berr_o),
    .rdata_o(rdata_o), .fault_i(fault_i), .sysfail_o(sysfail_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input logic [7:0] a, input bit wide);
    int rel;
    if (a[0]) return 0;
    if (a == 0) return !wide;
    if (a < 8 || a >= 8'hF8) return 0;
    if (!wide) return 1;
    rel = (int'(a) - 8) % 40;
    return rel inside {4, 8, 12, 16, 28, 32, 36};
  endfunction

  task automatic access(input bit we, input bit wide, input logic [7:0] a,
                        input logic [31:0] wd, input string tag);
    exp_t e;
    int w;
    w = int'(a >> 1);
    e.err = !legal(a, wide);
    e.chk = !e.err && !we;
    e.tag = tag;
    e.data = wide ? {mdl[w], mdl[(w + 1) % 128]} : {16'h0000, mdl[w]};
    if (!e.err && we) begin
      if (a == 0) mdl[0] = wd[15:0] & 16'h4000;
      else if (wide) begin mdl[w] = wd[31:16]; mdl[w + 1] = wd[15:0]; end
      else mdl[w] = wd[15:0];
    end
    @(negedge clk_i);
    sb.push_back(e);
    n_req++;
    req_i = 1'b1; we_i = we; wide_i = wide; addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk_i) begin
    if (rst_ni && (ack_o || berr_o)) begin
      exp_t e;
      n_resp++;
      if (ack_o && berr_o) check(0, "R6 both ack and berr", 32'(ack_o), 0);
      if (sb.size() == 0) check(0, "R6 unexpected response", 32'(ack_o), 0);
      else begin
        e = sb.pop_front();
        check(berr_o == e.err, {e.tag, " err"}, 32'(berr_o), 32'(e.err));
        if (e.chk) check(rdata_o == e.data, {e.tag, " data"}, rdata_o, e.data);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    fault_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!ack_o && !berr_o, "R1 idle after reset", {ack_o, berr_o}, 0);
    check(sysfail_o == 1'b1, "R8 unmasked fault", 32'(sysfail_o), 1);
    access(0, 0, 8'h00, 0, "R1 R7 global reset read");
    access(0, 0, 8'h08, 0, "R1 ch0 reset read");
    access(0, 1, 8'hF4, 0, "R1 ch5 result reset read");
    for (int c = 0; c < 6; c++) access(1, 0, 8'(8 + 40 * c), 32'h1000 + c, "R2 R9 ctrl write");
    for (int c = 0; c < 6; c++) access(0, 0, 8'(8 + 40 * c), 0, "R2 R9 ctrl read");
    access(1, 1, 8'h0C, 32'hAAAA5555, "R3 wide write ch0 rate");
    access(0, 0, 8'h0C, 0, "R3 lower word high half");
    access(0, 0, 8'h0E, 0, "R3 upper word low half");
    access(0, 1, 8'h0C, 0, "R3 wide read ch0 rate");
    access(1, 1, 8'h34, 32'h0BAD_F00D, "R3 R9 wide write ch1 rate");
    access(0, 1, 8'h0C, 0, "R9 ch0 rate unchanged");
    access(1, 1, 8'hF4, 32'h12345678, "R3 wide write ch5 result");
    access(0, 0, 8'hF6, 0, "R3 ch5 result low word");
    access(1, 1, 8'h08, 32'hDEADBEEF, "R4 wide write ctrl refused");
    access(0, 0, 8'h08, 0, "R4 ctrl unchanged");
    access(0, 0, 8'h0A, 0, "R4 neighbour unchanged");
    access(1, 1, 8'h0E, 32'hCAFE0001, "R4 wide write mid-pair refused");
    access(0, 0, 8'h0E, 0, "R4 word unchanged");
    access(0, 0, 8'h10, 0, "R4 next word unchanged");
    access(0, 1, 8'h1C, 0, "R4 wide read refused");
    access(0, 1, 8'h30, 0, "R4 wide read ch1 ctrl refused");
    access(0, 0, 8'hF8, 0, "R5 above map read");
    access(1, 1, 8'hFC, 32'h1, "R5 above map wide write");
    access(1, 0, 8'h04, 32'hFFFF, "R5 gap write");
    access(1, 0, 8'h09, 32'h7777, "R5 odd write");
    access(0, 0, 8'h08, 0, "R5 ctrl unchanged after odd write");
    access(1, 1, 8'h00, 32'hFFFFFFFF, "R7 wide global refused");
    access(1, 0, 8'h00, 32'hFFFF, "R7 global write");
    check(sysfail_o == 1'b0, "R8 masked fault", 32'(sysfail_o), 0);
    access(0, 0, 8'h00, 0, "R7 global readback reserved zero");
    access(1, 0, 8'h00, 32'h0000, "R7 global clear");
    check(sysfail_o == 1'b1, "R8 unmasked again", 32'(sysfail_o), 1);
    fault_i = 1'b0;
    @(negedge clk_i);
    check(sysfail_o == 1'b0, "R8 no fault", 32'(sysfail_o), 0);
    repeat (3) @(negedge clk_i);
    check(sb.size() == 0 && n_req == n_resp, "R6 one response per request",
          32'(n_resp), 32'(n_req));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule